// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Lock Monitor

This block is the digital half of a fixed-ratio integer-N frequency synthesizer. It divides the reference clock by a programmable ratio R and divides the VCO clock by a fixed feedback ratio. Both divided streams then drive a two-flop phase-frequency detector, which produces charge-pump up and down requests. The block also derives two clocks from the VCO. One is an IF local-oscillator tick at VCO/IF_DIV. The other is an LO-derived sample tick at VCO/(2·IF_DIV). A selector chooses either that LO-derived tick or the raw reference as the converter sample clock.

All clocks enter as one-cycle tick strobes in the system clock domain. Examples are a reference edge detected upstream, or a prescaled VCO edge. A configuration input holds every divider and the detector in reset and releases the charge pump. Two active-low override requests pin the VCO to one extreme. A request for both extremes at once is treated as a request for neither.

A lock monitor sorts each comparison period by how many feedback pulses fell inside it. It then raises a directional out-of-lock flag once one class has persisted for LOCK_WIN periods in a row. With the intended settings, the comparison rate is 200 kHz: R = f_ref / 200 kHz, FB_DIV = 16128, and IF_DIV = 96.

Top module: `pll_divlock`

## Requirements
- R1: The detector receives one reference pulse for every R `ref_tick` strobes, where R is `ref_div_ratio`. A ratio of 0 or 1 divides by one. In steady lock, `pump_up` therefore rises once per R reference ticks.
- R2: The detector receives one feedback pulse for every FB_DIV `vco_tick` strobes (default 16128). In steady lock, `pump_dn` rises once per FB_DIV VCO ticks.
- R3: `pump_up` and `pump_dn` are never both high for two consecutive cycles. Whenever both are high, both are low in the next cycle.
- R4: `if_lo_tick` pulses once per IF_DIV `vco_tick` strobes (default 96).
- R5: With `samp_src_ref` = 1, `samp_tick` pulses once per `ref_tick`, delayed by one cycle. This path works even while the dividers are held. With `samp_src_ref` = 0, `samp_tick` pulses once per 2·IF_DIV `vco_tick` strobes.
- R6: While `div_run` = 0, the following all stay low: `pump_drive`, `pump_up`, `pump_dn`, `if_lo_tick`, the LO-derived `samp_tick`, and both unlock flags. All divider counts restart from zero.
- R7: The override outputs depend on the two active-low requests. `ovr_lo_n` = 0 alone gives `force_vco_lo` = 1. `ovr_hi_n` = 0 alone gives `force_vco_hi` = 1. Both at 0, or both at 1, leave both outputs at 0. The outputs update one cycle after the inputs.
- R8: A comparison period closes on each divided reference pulse. A feedback pulse in that same cycle counts toward the closing period. After LOCK_WIN consecutive periods holding two or more feedback pulses, `unlock_hi` = 1 and `unlock_lo` = 0.
- R9: After LOCK_WIN consecutive periods holding no feedback pulse, `unlock_lo` = 1 and `unlock_hi` = 0.
- R10: After LOCK_WIN consecutive periods holding exactly one feedback pulse, both unlock flags are 0.
- R11: During `rst`, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock edge |
| vco_tick | input | 1 | One-cycle strobe per VCO clock edge |
| ref_div_ratio | input | 8 | Reference division ratio R |
| samp_src_ref | input | 1 | 1: sample clock from reference, 0: from LO divider |
| div_run | input | 1 | 0 holds dividers and detector, pump released |
| ovr_lo_n | input | 1 | Active-low request to pin VCO at lowest frequency |
| ovr_hi_n | input | 1 | Active-low request to pin VCO at highest frequency |
| pump_up | output | 1 | Charge-pump up request |
| pump_dn | output | 1 | Charge-pump down request |
| pump_drive | output | 1 | Pump output enable (0 = high impedance) |
| force_vco_lo | output | 1 | Pin VCO to lowest frequency |
| force_vco_hi | output | 1 | Pin VCO to highest frequency |
| unlock_hi | output | 1 | Out of lock, feedback running fast |
| unlock_lo | output | 1 | Out of lock, feedback running slow or stuck |
| samp_tick | output | 1 | Sample clock strobe |
| if_lo_tick | output | 1 | IF local-oscillator strobe |

## Verification
The divider chain is driven at matched ratios, with R drawn at random from 1 to 4 and the VCO tick spacing set to match it. This separates a wrong reference count from a wrong feedback count, because the two pulse totals are checked independently against the issued ticks.

Three lock-monitor patterns are used, and each must produce its own flag pattern:
- a VCO running twice too fast;
- a stopped VCO;
- matched rates.

A zero ratio confirms the divide-by-one floor. Holding the dividers with the ticks still running shows the reference-fed sample path stays live while every LO-derived output stops.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

    typedef enum logic [1:0] {
        PER_OK   = 2'd0,
        PER_FAST = 2'd1,
        PER_SLOW = 2'd2
    } per_class_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

    typedef struct packed {
        logic lo;
        logic hi;
    } vco_force_t;

    // Sort one comparison period by its feedback pulse count
    function automatic per_class_e classify(input logic [1:0] n);
        if (n == 2'd0)      return PER_SLOW;
        else if (n == 2'd1) return PER_OK;
        else                return PER_FAST;
    endfunction

    // Active-low requests; a conflicting pair cancels out
    function automatic vco_force_t decode_force(input logic lo_n, input logic hi_n);
        vco_force_t f;
        f.lo = ~lo_n & hi_n;
        f.hi = ~hi_n & lo_n;
        return f;
    endfunction

endpackage

// File: rtl/pll_tick_div.sv
module pll_tick_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    logic [W-1:0] cnt;
    logic [W-1:0] last;

    assign last = (ratio == '0) ? '0 : ratio - W'(1);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (tick) begin
            if (cnt >= last) begin
                cnt   <= '0;
                pulse <= 1'b1;
            end else begin
                cnt   <= cnt + W'(1);
                pulse <= 1'b0;
            end
        end else begin
            pulse <= 1'b0;
        end
    end

    // R1
    div_pulse_from_tick_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(tick));

    // R6
    div_hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> !pulse);

endmodule

// File: rtl/pll_pfd.sv
module pll_pfd
    import pll_div_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  logic  ref_p,
    input  logic  fb_p,
    output pump_t q
);
    logic both;
    assign both = q.up & q.dn;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            q <= '0;
        end else begin
            q.up <= ~both & (q.up | ref_p);
            q.dn <= ~both & (q.dn | fb_p);
        end
    end

    // R3
    pfd_no_stuck_both_chk: assert property (@(posedge clk) disable iff (rst)
        (q.up && q.dn) |=> !(q.up && q.dn));

endmodule

// File: rtl/pll_lock_mon.sv
module pll_lock_mon
    import pll_div_pkg::*;
#(
    parameter int LOCK_WIN = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic ref_p,
    input  logic fb_p,
    output logic unlock_hi,
    output logic unlock_lo
);
    localparam int RW = $clog2(LOCK_WIN + 1);

    logic [1:0]    fb_seen;
    logic [1:0]    n_close;
    per_class_e    cur_cls;
    per_class_e    cls;
    logic [RW-1:0] run;
    logic [RW-1:0] run_next;

    always_comb begin
        n_close = (fb_seen >= 2'd2 || (fb_seen == 2'd1 && fb_p)) ? 2'd2
                                                                  : fb_seen + {1'b0, fb_p};
        cls = classify(n_close);
        if (cls == cur_cls)
            run_next = (run == RW'(LOCK_WIN)) ? run : run + RW'(1);
        else
            run_next = RW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            fb_seen   <= '0;
            cur_cls   <= PER_OK;
            run       <= '0;
            unlock_hi <= 1'b0;
            unlock_lo <= 1'b0;
        end else if (ref_p) begin
            fb_seen <= '0;
            cur_cls <= cls;
            run     <= run_next;
            if (run_next == RW'(LOCK_WIN)) begin
                unlock_hi <= (cls == PER_FAST);
                unlock_lo <= (cls == PER_SLOW);
            end
        end else if (fb_p && fb_seen != 2'd3) begin
            fb_seen <= fb_seen + 2'd1;
        end
    end

    // R8
    lock_flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(unlock_hi && unlock_lo));

    // R10
    lock_flags_move_on_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !$past(hold) && !$past(ref_p)) |-> ($stable(unlock_hi) && $stable(unlock_lo)));

endmodule

// File: rtl/pll_divlock.sv
module pll_divlock
    import pll_div_pkg::*;
#(
    parameter int FB_DIV   = 16128,
    parameter int IF_DIV   = 96,
    parameter int LOCK_WIN = 256,
    parameter int REF_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             vco_tick,
    input  logic [REF_W-1:0] ref_div_ratio,
    input  logic             samp_src_ref,
    input  logic             div_run,
    input  logic             ovr_lo_n,
    input  logic             ovr_hi_n,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             pump_drive,
    output logic             force_vco_lo,
    output logic             force_vco_hi,
    output logic             unlock_hi,
    output logic             unlock_lo,
    output logic             samp_tick,
    output logic             if_lo_tick
);
    localparam int SAMP_DIV = 2 * IF_DIV;
    localparam int FB_W     = $clog2(FB_DIV + 1);
    localparam int IF_W     = $clog2(IF_DIV + 1);
    localparam int SAMP_W   = $clog2(SAMP_DIV + 1);

    logic       hold;
    logic       ref_p;
    logic       fb_p;
    logic       lo_samp_p;
    pump_t      pump;
    vco_force_t frc;

    assign hold = ~div_run;

    pll_tick_div #(.W(REF_W)) u_ref_div (
        .clk(clk), .rst(rst), .hold(hold), .tick(ref_tick),
        .ratio(ref_div_ratio), .pulse(ref_p));

    pll_tick_div #(.W(FB_W)) u_fb_div (
        .clk(clk), .rst(rst), .hold(hold), .tick(vco_tick),
        .ratio(FB_W'(FB_DIV)), .pulse(fb_p));

    pll_tick_div #(.W(IF_W)) u_if_div (
        .clk(clk), .rst(rst), .hold(hold), .tick(vco_tick),
        .ratio(IF_W'(IF_DIV)), .pulse(if_lo_tick));

    pll_tick_div #(.W(SAMP_W)) u_samp_div (
        .clk(clk), .rst(rst), .hold(hold), .tick(vco_tick),
        .ratio(SAMP_W'(SAMP_DIV)), .pulse(lo_samp_p));

    pll_pfd u_pfd (
        .clk(clk), .rst(rst), .hold(hold),
        .ref_p(ref_p), .fb_p(fb_p), .q(pump));

    pll_lock_mon #(.LOCK_WIN(LOCK_WIN)) u_lock (
        .clk(clk), .rst(rst), .hold(hold), .ref_p(ref_p), .fb_p(fb_p),
        .unlock_hi(unlock_hi), .unlock_lo(unlock_lo));

    assign pump_up = pump.up;
    assign pump_dn = pump.dn;

    always_ff @(posedge clk) begin
        if (rst) begin
            pump_drive <= 1'b0;
            frc        <= '0;
            samp_tick  <= 1'b0;
        end else begin
            pump_drive <= div_run;
            frc        <= decode_force(ovr_lo_n, ovr_hi_n);
            samp_tick  <= samp_src_ref ? ref_tick : lo_samp_p;
        end
    end

    assign force_vco_lo = frc.lo;
    assign force_vco_hi = frc.hi;

    // R7
    force_conflict_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (!ovr_lo_n && !ovr_hi_n) |=> (!force_vco_lo && !force_vco_hi));

    // R6
    hold_releases_pump_chk: assert property (@(posedge clk) disable iff (rst)
        !div_run |=> (!pump_drive && !if_lo_tick));

    // R5
    samp_follows_ref_chk: assert property (@(posedge clk) disable iff (rst)
        samp_src_ref |=> (samp_tick == $past(ref_tick)));

endmodule

// File: tb/tb_pll_divlock.sv
module tb_pll_divlock;
    localparam int FB_DIV = 8;
    localparam int IF_DIV = 3;
    localparam int WIN    = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0, vco_tick = 1'b0;
    logic [7:0] ratio = 8'd2;
    logic       samp_src_ref = 1'b0, div_run = 1'b1;
    logic       ovr_lo_n = 1'b1, ovr_hi_n = 1'b1;
    logic       pump_up, pump_dn, pump_drive, force_vco_lo, force_vco_hi;
    logic       unlock_hi, unlock_lo, samp_tick, if_lo_tick;

    pll_divlock #(.FB_DIV(FB_DIV), .IF_DIV(IF_DIV), .LOCK_WIN(WIN)) dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .vco_tick(vco_tick),
        .ref_div_ratio(ratio), .samp_src_ref(samp_src_ref), .div_run(div_run),
        .ovr_lo_n(ovr_lo_n), .ovr_hi_n(ovr_hi_n), .pump_up(pump_up), .pump_dn(pump_dn),
        .pump_drive(pump_drive), .force_vco_lo(force_vco_lo), .force_vco_hi(force_vco_hi),
        .unlock_hi(unlock_hi), .unlock_lo(unlock_lo), .samp_tick(samp_tick),
        .if_lo_tick(if_lo_tick));

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    int ref_per = 0, vco_per = 0;
    int ref_cnt = 0, vco_cnt = 0;
    int ref_issued = 0, vco_issued = 0;
    int up_rises = 0, dn_rises = 0, if_cnt = 0, samp_cnt = 0;
    int both_viol = 0;
    logic up_prev = 1'b0, dn_prev = 1'b0, both_prev = 1'b0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit near(input int a, input int b);
        return (a - b <= 1) && (b - a <= 1);
    endfunction

    task automatic clear_counts();
        ref_issued = 0; vco_issued = 0;
        up_rises = 0; dn_rises = 0; if_cnt = 0; samp_cnt = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor outputs and drive tick strobes away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (pump_up && !up_prev) up_rises++;
            if (pump_dn && !dn_prev) dn_rises++;
            if (if_lo_tick) if_cnt++;
            if (samp_tick) samp_cnt++;
            if (!rst && both_prev && pump_up && pump_dn) both_viol++;
            both_prev = pump_up && pump_dn;
            up_prev = pump_up;
            dn_prev = pump_dn;
            ref_cnt++;
            if (ref_per != 0 && ref_cnt >= ref_per) begin
                ref_tick = 1'b1; ref_cnt = 0; ref_issued++;
            end else ref_tick = 1'b0;
            vco_cnt++;
            if (vco_per != 0 && vco_cnt >= vco_per) begin
                vco_tick = 1'b1; vco_cnt = 0; vco_issued++;
            end else vco_tick = 1'b0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        wait_cyc(4);
        // R11 reset state
        chk({pump_up, pump_dn, pump_drive, force_vco_lo, force_vco_hi,
             unlock_hi, unlock_lo, samp_tick, if_lo_tick} == 9'd0, "R11", 1, 0);
        rst = 1'b0;
        wait_cyc(2);
        chk(pump_drive == 1'b1, "R6 drive on", pump_drive, 1);

        // R7 override decode
        ovr_lo_n = 1'b0; ovr_hi_n = 1'b1; wait_cyc(2);
        chk(force_vco_lo && !force_vco_hi, "R7 lo", {force_vco_lo, force_vco_hi}, 2);
        ovr_lo_n = 1'b1; ovr_hi_n = 1'b0; wait_cyc(2);
        chk(!force_vco_lo && force_vco_hi, "R7 hi", {force_vco_lo, force_vco_hi}, 1);
        ovr_lo_n = 1'b0; ovr_hi_n = 1'b0; wait_cyc(2);
        chk(!force_vco_lo && !force_vco_hi, "R7 both", {force_vco_lo, force_vco_hi}, 0);
        ovr_lo_n = 1'b1; ovr_hi_n = 1'b1; wait_cyc(2);
        chk(!force_vco_lo && !force_vco_hi, "R7 none", {force_vco_lo, force_vco_hi}, 0);

        // Random matched-rate runs: R1 R2 R4 R5 R10
        for (int it = 0; it < 5; it++) begin
            int r;
            r = $urandom_range(1, 4);
            ratio = 8'(r);
            samp_src_ref = $urandom_range(0, 1);
            ref_per = 8; vco_per = r;
            wait_cyc(350);
            clear_counts();
            wait_cyc(800);
            chk(near(up_rises, ref_issued / r), "R1", up_rises, ref_issued / r);
            chk(near(dn_rises, vco_issued / FB_DIV), "R2", dn_rises, vco_issued / FB_DIV);
            chk(near(if_cnt, vco_issued / IF_DIV), "R4", if_cnt, vco_issued / IF_DIV);
            if (samp_src_ref)
                chk(near(samp_cnt, ref_issued), "R5 ref", samp_cnt, ref_issued);
            else
                chk(near(samp_cnt, vco_issued / (2 * IF_DIV)), "R5 lo", samp_cnt,
                    vco_issued / (2 * IF_DIV));
            chk(!unlock_hi && !unlock_lo, "R10", {unlock_hi, unlock_lo}, 0);
        end

        // R1 zero ratio acts as divide by one
        samp_src_ref = 1'b0;
        ratio = 8'd0; ref_per = 8; vco_per = 1;
        wait_cyc(200);
        clear_counts();
        wait_cyc(400);
        chk(near(up_rises, ref_issued), "R1 zero", up_rises, ref_issued);

        // R8 feedback twice too fast
        ratio = 8'd2; ref_per = 8; vco_per = 1;
        wait_cyc(400);
        chk(unlock_hi && !unlock_lo, "R8", {unlock_hi, unlock_lo}, 2);

        // R6 hold with ticks running
        div_run = 1'b0;
        wait_cyc(3);
        clear_counts();
        wait_cyc(100);
        chk(up_rises == 0 && dn_rises == 0, "R6 pump", up_rises + dn_rises, 0);
        chk(if_cnt == 0 && samp_cnt == 0, "R6 lo", if_cnt + samp_cnt, 0);
        chk(!pump_drive && !unlock_hi && !unlock_lo, "R6 flags",
            {pump_drive, unlock_hi, unlock_lo}, 0);
        samp_src_ref = 1'b1;
        wait_cyc(3);
        clear_counts();
        wait_cyc(100);
        chk(near(samp_cnt, ref_issued), "R5 hold", samp_cnt, ref_issued);
        samp_src_ref = 1'b0;
        div_run = 1'b1;

        // R9 stopped VCO
        vco_per = 0;
        wait_cyc(400);
        chk(unlock_lo && !unlock_hi, "R9", {unlock_hi, unlock_lo}, 1);

        // R10 recovery to matched rate
        vco_per = 2;
        wait_cyc(400);
        chk(!unlock_hi && !unlock_lo, "R10 recover", {unlock_hi, unlock_lo}, 0);

        // R3 over whole run
        chk(both_viol == 0, "R3", both_viol, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule